// File: doc/BRIEF.md
# Microstep Sequencer with Ready Stall

This block produces the step number a microcoded instruction decoder uses to pick the micro-operation inside the current instruction. The step is five bits wide. Its lowest bit is the current clock phase, and its upper four bits come from a binary counter. The counter moves forward once per full clock, when the phase falls from high to low. Everything runs on one synchronous system clock. A phase-enable input marks the system-clock cycles in which the external clock phase flips.

The decoder ends an instruction by raising an end-of-instruction bit during an odd step. At the next falling phase the upper counter loads zero instead of incrementing. The block keeps a request that arrives while a stall holds the count, and it serves each request only once. A ready input is sampled at every falling-phase slot. When it is low, the count freezes with bit 0 forced high until a later slot finds ready high again. While the upper counter is zero the block drives a sync output. When a new instruction begins it emits a one-cycle strobe that loads the opcode and interrupt latches.

Top module: `mstep_seq`

## Requirements
- R1: After reset the internal phase is low. Each cycle with `ph_en` high flips it, and `step[0]` equals this phase unless the count is frozen.
- R2: The upper field `step[4:1]` changes only at an advance. An advance is a cycle in which `ph_en` is high, the internal phase is high and `rdy` is high. Without a pending clear it adds one, and 15 wraps to 0 with no strobe.
- R3: While `rst` is high (sampled synchronously) the next state is `step` = 0, `sync` = 1 and `latch_strobe` = 0.
- R4: If `eoi` is high in a cycle where `step[0]` = 1, the same or the next advance loads the upper field with 0 instead of incrementing, so `step` becomes 0.
- R5: If `eoi` is high only in cycles where `step[0]` = 0, it has no effect and the count keeps incrementing.
- R6: A request clears the counter once. After a clear, `eoi` is ignored until it has been seen low for at least one cycle.
- R7: A falling-phase slot (`ph_en` high with the internal phase high) that samples `rdy` low freezes the count: there is no advance and `step[0]` stays 1. The internal phase keeps flipping, and every later falling-phase slot samples `rdy` again. The first slot that finds it high advances and releases the freeze.
- R8: An end-of-instruction request seen while the count is frozen is kept and applied at the advance that ends the freeze.
- R9: `sync` is 1 exactly when the upper field is 0.
- R10: `latch_strobe` is high for one cycle together with the first cycle of step 0 after a clear. It is also high in the cycle after the first clock edge with `rst` low. It never fires on a wrap or while the count is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_en | input | 1 | Phase flips at this clock edge |
| rdy | input | 1 | Ready; low requests a stall |
| eoi | input | 1 | End-of-instruction bit from the decoder |
| step | output | 5 | Step number: {upper counter, phase} |
| sync | output | 1 | First-cycle marker (upper counter zero) |
| latch_strobe | output | 1 | One-cycle opcode/interrupt latch pulse |

## Verification
The assertions expect `rst` to be driven to a known level from the first clock edge. They also expect `eoi`, `rdy` and `ph_en` to change only between edges, so that each property sees one value per cycle. The only sequencing they assume is what the phase register imposes: an advance can happen only when the internal phase is high. The stimulus changes all inputs at the falling clock edge. It covers long stretches of steady phase enables, sparse enables, held and pulsed end-of-instruction requests, ready stalls with requests arriving mid-stall, and a long pseudo-random mix that includes reset pulses.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    // Default width of the upper (full-cycle) counter.
    localparam int unsigned UPPER_W_DEF = 4;

    // Phase state: raw clock phase and the ready freeze flag.
    typedef struct packed {
        logic ph;
        logic frz;
    } phase_t;

    // A request is taken when eoi is high in an odd half and not blocked.
    function automatic logic eoi_hit(input logic eoi, input logic odd, input logic blk);
        return eoi && odd && !blk;
    endfunction

endpackage

// File: rtl/mstep_phase.sv
module mstep_phase
    import mstep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ph_en,
    input  logic rdy,
    output logic adv,
    output logic odd
);
    phase_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (ph_en) st.ph <= !st.ph;
            if (ph_en && st.ph) st.frz <= !rdy;
        end
    end

    assign adv = ph_en && st.ph && rdy;
    assign odd = st.ph || st.frz;

    // R7: a frozen count stays on an odd step until an advance occurs
    assert_frz_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st.frz && !adv) |=> odd);

endmodule

// File: rtl/mstep_eoi.sv
module mstep_eoi
    import mstep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eoi,
    input  logic odd,
    input  logic adv,
    output logic clr
);
    logic pend;
    logic blk;
    logic hit;

    assign hit = eoi_hit(eoi, odd, blk);
    assign clr = adv && (pend || hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            blk  <= 1'b0;
        end else if (clr) begin
            pend <= 1'b0;
            blk  <= eoi;
        end else begin
            pend <= (pend || hit) && !adv;
            blk  <= blk && eoi;
        end
    end

    // R6: once a clear is served, no request remains pending
    assert_once_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pend);

    // R8: a stored request is only dropped by an advance
    assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (pend && !adv) |=> pend);

endmodule

// File: rtl/mstep_count.sv
module mstep_count #(
    parameter int unsigned UW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          clr,
    output logic [UW-1:0] upper,
    output logic          strobe
);
    logic start;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper  <= '0;
            start  <= 1'b1;
            strobe <= 1'b0;
        end else begin
            strobe <= start || clr;
            start  <= 1'b0;
            if (adv) upper <= clr ? '0 : upper + 1'b1;
        end
    end

    // R2: without an advance the upper field holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(upper));

    // R2: a plain advance adds exactly one
    assert_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr) |=> (upper == UW'($past(upper) + 1'b1)));

    // R10: the latch strobe only coincides with a zero upper field
    assert_stb_zero_R10: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (upper == '0));

endmodule

// File: rtl/mstep_seq.sv
module mstep_seq #(
    parameter int unsigned UW = mstep_pkg::UPPER_W_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ph_en,
    input  logic        rdy,
    input  logic        eoi,
    output logic [UW:0] step,
    output logic        sync,
    output logic        latch_strobe
);
    logic          adv;
    logic          odd;
    logic          clr;
    logic [UW-1:0] upper;

    mstep_phase u_phase (
        .clk  (clk),
        .rst  (rst),
        .ph_en(ph_en),
        .rdy  (rdy),
        .adv  (adv),
        .odd  (odd)
    );

    mstep_eoi u_eoi (
        .clk(clk),
        .rst(rst),
        .eoi(eoi),
        .odd(odd),
        .adv(adv),
        .clr(clr)
    );

    mstep_count #(.UW(UW)) u_count (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .clr   (clr),
        .upper (upper),
        .strobe(latch_strobe)
    );

    assign step = {upper, odd};
    assign sync = (upper == '0);

    // R3: reset forces step zero, sync high and no strobe
    assert_rst_R3: assert property (@(posedge clk)
        rst |=> (step == '0 && sync && !latch_strobe));

    // R1: phase cannot change without a phase enable
    assert_phase_R1: assert property (@(posedge clk) disable iff (rst)
        (!ph_en && !$past(rst)) |=> $stable(step));

endmodule

// File: tb/mstep_seq_tb.sv
module mstep_seq_tb;
    logic       clk = 1'b0;
    logic       rst, ph_en, rdy, eoi;
    logic [4:0] step;
    logic       sync, latch_strobe;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned seed = 32'h1234_5678;

    // behavioural reference state
    int m_ph, m_frz, m_up, m_pend, m_blk, m_start, m_stb;

    always #10 clk = ~clk;

    mstep_seq u_dut (
        .clk(clk), .rst(rst), .ph_en(ph_en), .rdy(rdy), .eoi(eoi),
        .step(step), .sync(sync), .latch_strobe(latch_strobe)
    );

    function automatic int m_odd();
        return (m_ph != 0 || m_frz != 0) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // advance the reference model by one clock edge with the applied inputs
    task automatic model_next();
        int hit, req, slot, adv, stb_n;
        if (rst) begin
            m_ph = 0; m_frz = 0; m_up = 0; m_pend = 0; m_blk = 0;
            m_start = 1; m_stb = 0;
        end else begin
            hit   = (eoi && m_odd() != 0 && m_blk == 0) ? 1 : 0;
            req   = (m_pend != 0 || hit != 0) ? 1 : 0;
            slot  = (ph_en && m_ph != 0) ? 1 : 0;
            adv   = (slot != 0 && rdy) ? 1 : 0;
            stb_n = m_start;
            m_start = 0;
            if (slot != 0) m_frz = rdy ? 0 : 1;
            if (ph_en) m_ph = 1 - m_ph;
            if (adv != 0 && req != 0) begin
                m_up = 0; m_pend = 0; m_blk = eoi ? 1 : 0; stb_n = 1;
            end else begin
                if (adv != 0) m_up = (m_up + 1) % 16;
                m_pend = (req != 0 && adv == 0) ? 1 : 0;
                m_blk  = (m_blk != 0 && eoi) ? 1 : 0;
            end
            m_stb = stb_n;
        end
    endtask

    task automatic cyc(input string tag, input bit r, input bit pe, input bit rd, input bit e);
        rst = r; ph_en = pe; rdy = rd; eoi = e;
        model_next();
        @(negedge clk);
        chk(tag, "step", int'(step), m_up * 2 + m_odd());
        chk("R9", "sync", int'(sync), (m_up == 0) ? 1 : 0);
        chk("R10", "latch_strobe", int'(latch_strobe), m_stb);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R3: reset state
        for (int i = 0; i < 3; i++) cyc("R3", 1, 1, 1, 1);
        chk("R3", "reset step", int'(step), 0);
        chk("R3", "reset sync", int'(sync), 1);

        // R2: steady enables, full wrap of the upper field
        for (int i = 0; i < 70; i++) cyc("R2", 0, 1, 1, 0);

        // R1: sparse phase enables
        for (int i = 0; i < 45; i++) cyc("R1", 0, (i % 3) == 0, 1, 0);

        // R4: single-cycle eoi pulses on odd steps
        for (int i = 0; i < 60; i++)
            cyc("R4", 0, 1, 1, (i % 9) > 4 && m_odd() != 0);

        // R5: eoi only on even steps, enables every other cycle
        for (int i = 0; i < 60; i++) cyc("R5", 0, (i % 2) == 0, 1, m_odd() == 0);

        // R6: eoi held high for long stretches
        for (int i = 0; i < 60; i++) cyc("R6", 0, 1, 1, (i % 20) < 14);

        // R7: ready low stalls
        for (int i = 0; i < 60; i++) cyc("R7", 0, 1, !((i % 15) >= 3 && (i % 15) < 11), 0);

        // R8: request arriving during a stall
        for (int i = 0; i < 60; i++)
            cyc("R8", 0, 1, !((i % 15) >= 2 && (i % 15) < 10), (i % 15) == 5);

        // mixed pseudo-random traffic
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            cyc("R9", seed[23:16] == 8'd0, seed[17] | seed[18],
                seed[21:19] != 3'd0, seed[26:24] == 3'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule